// File: doc/BRIEF.md
# LPI configuration cache invalidator

This block holds a small cache of per-interrupt configuration bytes for message-signalled interrupts and exposes one write-only 64-bit invalidate register. A write names an interrupt ID and, for virtual targets, a virtual-PE ID. If the ID lies in the implemented range and the matching entry is cached, the entry is dropped. Its configuration byte is then read again from the in-memory property table over a request/response read port. The fetched byte is stored back into the same entry.

If the reloaded interrupt is the one currently handed to the CPU, and the CPU has not activated it yet, the block pulses a recall. It also pulses a re-forward carrying the new priority, but only when the reloaded byte keeps the interrupt enabled. Other logic fills the cache through a slot-indexed fill port. Interrupt delivery logic reads the cache through a combinational query port.

Top module: `lpi_inval_unit`

## Requirements
- R1: Only a write whose offset equals 0x0A0 is decoded. A write at any other offset changes no cache entry and issues no memory request.
- R2: When `wr_is32` is high, bits 63:32 of `wr_data` are taken as zero before decode. Such a write therefore always names a physical target.
- R3: Bit 63 set means a virtual target. The virtual-PE ID is then bits [32 +: VPE_BITS]. It is forced to zero when bit 63 is clear. Bits 62:48 and any virtual-PE bits above VPE_BITS are ignored. A cache match needs the target type, the virtual-PE ID and the interrupt ID all to be equal.
- R4: Only bits [ID_BITS-1:0] of the ID field are used. A decoded ID below 8192 is out of range, and a write naming it has no effect.
- R5: A write whose decoded target is not cached has no effect. No request is issued and `wr_ready` stays high.
- R6: An accepted write makes the following changes, all visible the next cycle. The entry stops hitting. `wr_ready` falls. `mem_req` rises with `mem_addr` equal to `prop_base + (ID - 8192)`.
- R7: `mem_req` and `mem_addr` hold until `mem_ack`. In the cycle after the acknowledging edge, the entry hits again with `q_prop` equal to the returned byte, and `wr_ready` is high.
- R8: The recall check is made at the acknowledging edge. If `fwd_valid` is high, `fwd_active` is low, the target is physical and `fwd_id` equals the reloaded ID, `recall` pulses for one cycle after that edge. In the same cycle, `reforward` pulses with `refwd_id` set to the ID. It does so only if bit 0 (enable) of the returned byte is 1, and `refwd_prio` then carries bits 7:2 of the byte.
- R9: No recall or re-forward occurs in any of these cases: the forwarded interrupt is already active, nothing is forwarded, the forwarded ID differs, or the target is virtual.
- R10: While a reload is outstanding, `wr_ready` is low and any write is ignored.
- R11: A read pulses `rd_valid` one cycle later with `rd_data` equal to zero. It has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | OFF_W | Write byte offset in the frame |
| wr_is32 | input | 1 | Write is 32 bits wide |
| wr_data | input | 64 | Write data |
| wr_ready | output | 1 | Write port can accept (low while busy) |
| rd_en | input | 1 | Register read strobe |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data, always zero |
| prop_base | input | AW | Property table base address |
| mem_req | output | 1 | Property fetch request |
| mem_addr | output | AW | Property byte address |
| mem_ack | input | 1 | Fetch response valid |
| mem_rdata | input | 8 | Fetched property byte |
| fill_en | input | 1 | Cache fill strobe |
| fill_slot | input | SW | Entry to fill |
| fill_virt | input | 1 | Fill tag: virtual target |
| fill_vpe | input | VPE_BITS | Fill tag: virtual-PE ID |
| fill_id | input | ID_BITS | Fill tag: interrupt ID |
| fill_prop | input | 8 | Fill property byte |
| q_virt | input | 1 | Query: virtual target |
| q_vpe | input | VPE_BITS | Query: virtual-PE ID |
| q_id | input | ID_BITS | Query: interrupt ID |
| q_hit | output | 1 | Query hits a valid entry |
| q_prop | output | 8 | Property byte of the hit entry |
| fwd_valid | input | 1 | An interrupt is forwarded to the CPU |
| fwd_id | input | ID_BITS | ID of the forwarded interrupt |
| fwd_active | input | 1 | The forwarded interrupt is activated |
| recall | output | 1 | One-cycle recall pulse |
| reforward | output | 1 | One-cycle re-forward pulse |
| refwd_id | output | ID_BITS | ID being recalled or re-forwarded |
| refwd_prio | output | 6 | Priority for the re-forward |

## Verification
The first results come one cycle after the accepting edge. The entry is invalidated, `wr_ready` falls and `mem_req` rises. The bench samples these at the next falling edge. It then holds `mem_ack` off for two cycles to confirm that the request and its address stay stable.

Reload results are due one cycle after the edge at which `mem_ack` is sampled: the refilled entry, `wr_ready` high again, and the recall and re-forward pulses. They are read at the following falling edge, and the pulses are checked to be gone one cycle later. Writes with no effect are checked at the same falling edge after the write, where `mem_req` must stay low and the targeted entry must still hit with its old byte.

// File: rtl/lpi_inval_unit.sv
module lpi_inval_unit #(
  parameter int ID_BITS  = 14,
  parameter int VPE_BITS = 4,
  parameter int ENTRIES  = 4,
  parameter int AW       = 32,
  parameter int OFF_W    = 12,
  parameter logic [OFF_W-1:0] REG_OFF = 12'h0A0,
  localparam int SW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [OFF_W-1:0]    wr_off,
  input  logic                wr_is32,
  input  logic [63:0]         wr_data,
  output logic                wr_ready,
  input  logic                rd_en,
  output logic                rd_valid,
  output logic [63:0]         rd_data,
  input  logic [AW-1:0]       prop_base,
  output logic                mem_req,
  output logic [AW-1:0]       mem_addr,
  input  logic                mem_ack,
  input  logic [7:0]          mem_rdata,
  input  logic                fill_en,
  input  logic [SW-1:0]       fill_slot,
  input  logic                fill_virt,
  input  logic [VPE_BITS-1:0] fill_vpe,
  input  logic [ID_BITS-1:0]  fill_id,
  input  logic [7:0]          fill_prop,
  input  logic                q_virt,
  input  logic [VPE_BITS-1:0] q_vpe,
  input  logic [ID_BITS-1:0]  q_id,
  output logic                q_hit,
  output logic [7:0]          q_prop,
  input  logic                fwd_valid,
  input  logic [ID_BITS-1:0]  fwd_id,
  input  logic                fwd_active,
  output logic                recall,
  output logic                reforward,
  output logic [ID_BITS-1:0]  refwd_id,
  output logic [5:0]          refwd_prio
);
  localparam logic [ID_BITS-1:0] LPI_FIRST = ID_BITS'(8192);

  logic                e_vld  [ENTRIES];
  logic                e_virt [ENTRIES];
  logic [VPE_BITS-1:0] e_vpe  [ENTRIES];
  logic [ID_BITS-1:0]  e_id   [ENTRIES];
  logic [7:0]          e_prop [ENTRIES];

  logic                busy;
  logic [SW-1:0]       pend_slot;
  logic                pend_virt;
  logic [ID_BITS-1:0]  pend_id;

  wire [63:0]          d      = wr_is32 ? {32'b0, wr_data[31:0]} : wr_data;
  wire                 d_virt = d[63];
  wire [VPE_BITS-1:0]  d_vpe  = d_virt ? d[32 +: VPE_BITS] : '0;
  wire [ID_BITS-1:0]   d_id   = d[ID_BITS-1:0];
  wire                 d_inrange = d_id >= LPI_FIRST;

  logic          w_hit, f_hit;
  logic [SW-1:0] w_slot, f_slot;

  always_comb begin
    w_hit = 1'b0; w_slot = '0;
    f_hit = 1'b0; f_slot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (e_vld[i] && e_virt[i] == d_virt && e_vpe[i] == d_vpe && e_id[i] == d_id) begin
        w_hit = 1'b1; w_slot = SW'(i);
      end
      if (e_vld[i] && e_virt[i] == q_virt && e_vpe[i] == q_vpe && e_id[i] == q_id) begin
        f_hit = 1'b1; f_slot = SW'(i);
      end
    end
  end

  assign q_hit    = f_hit;
  assign q_prop   = f_hit ? e_prop[f_slot] : 8'h00;
  assign wr_ready = !busy;
  assign rd_data  = '0;

  wire accept  = wr_en && !busy && wr_off == REG_OFF && d_inrange && w_hit;
  wire done    = mem_req && mem_ack;
  wire hit_fwd = fwd_valid && !fwd_active && !pend_virt && fwd_id == pend_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      pend_slot  <= '0;
      pend_virt  <= 1'b0;
      pend_id    <= '0;
      recall     <= 1'b0;
      reforward  <= 1'b0;
      refwd_id   <= '0;
      refwd_prio <= '0;
      rd_valid   <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) e_vld[i] <= 1'b0;
    end else begin
      rd_valid  <= rd_en;
      recall    <= 1'b0;
      reforward <= 1'b0;
      if (fill_en && !(busy && fill_slot == pend_slot)) e_vld[fill_slot] <= 1'b1;
      if (accept) begin
        e_vld[w_slot] <= 1'b0;
        busy      <= 1'b1;
        mem_req   <= 1'b1;
        mem_addr  <= prop_base + AW'(d_id) - AW'(LPI_FIRST);
        pend_slot <= w_slot;
        pend_virt <= d_virt;
        pend_id   <= d_id;
      end
      if (done) begin
        busy             <= 1'b0;
        mem_req          <= 1'b0;
        e_vld[pend_slot] <= 1'b1;
        recall           <= hit_fwd;
        reforward        <= hit_fwd && mem_rdata[0];
        refwd_id         <= pend_id;
        refwd_prio       <= mem_rdata[7:2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !(busy && fill_slot == pend_slot)) begin
      e_virt[fill_slot] <= fill_virt;
      e_vpe[fill_slot]  <= fill_vpe;
      e_id[fill_slot]   <= fill_id;
      e_prop[fill_slot] <= fill_prop;
    end
    if (done) e_prop[pend_slot] <= mem_rdata;
  end
endmodule

// File: rtl/lpi_inval_checker.sv
module lpi_inval_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          recall,
  input logic          reforward,
  input logic          rd_valid,
  input logic [63:0]   rd_data
);
  a_r6_req_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !wr_ready);
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r7_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> wr_ready);
  a_r8_refwd_with_recall: assert property (@(posedge clk) disable iff (!rst_n)
    reforward |-> recall);
  a_r8_recall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    recall |=> !recall);
  a_r10_no_req_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !mem_req);
  a_r11_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data == 64'd0);
endmodule

bind lpi_inval_unit lpi_inval_checker #(.AW(AW)) u_lpi_inval_checker (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .recall(recall),
  .reforward(reforward), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/test_lpi_inval_unit.sv
module test_lpi_inval_unit;
  localparam int IDB = 14, VB = 4, AW = 32;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic wr_en = 0, wr_is32 = 0, rd_en = 0, mem_ack = 0;
  logic [11:0] wr_off = 0;
  logic [63:0] wr_data = 0;
  logic [AW-1:0] prop_base = 32'h4000_0000;
  logic [7:0] mem_rdata = 0;
  logic fill_en = 0, fill_virt = 0, q_virt = 0;
  logic [1:0] fill_slot = 0;
  logic [VB-1:0] fill_vpe = 0, q_vpe = 0;
  logic [IDB-1:0] fill_id = 0, q_id = 0, fwd_id = 0;
  logic [7:0] fill_prop = 0;
  logic fwd_valid = 0, fwd_active = 0;
  wire wr_ready, rd_valid, mem_req, q_hit, recall, reforward;
  wire [63:0] rd_data;
  wire [AW-1:0] mem_addr;
  wire [7:0] q_prop;
  wire [IDB-1:0] refwd_id;
  wire [5:0] refwd_prio;

  lpi_inval_unit i_lpi_inval_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_is32(wr_is32),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .prop_base(prop_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fill_en(fill_en), .fill_slot(fill_slot),
    .fill_virt(fill_virt), .fill_vpe(fill_vpe), .fill_id(fill_id), .fill_prop(fill_prop),
    .q_virt(q_virt), .q_vpe(q_vpe), .q_id(q_id), .q_hit(q_hit), .q_prop(q_prop),
    .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_active(fwd_active), .recall(recall),
    .reforward(reforward), .refwd_id(refwd_id), .refwd_prio(refwd_prio));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic fill(input int slot, input bit v, input int vpe, input int id, input int prop);
    @(negedge clk);
    fill_en = 1; fill_slot = 2'(slot); fill_virt = v; fill_vpe = VB'(vpe);
    fill_id = IDB'(id); fill_prop = 8'(prop);
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(input bit v, input int vpe, input int id, input bit exp_hit,
                      input int exp_prop, input string tag);
    q_virt = v; q_vpe = VB'(vpe); q_id = IDB'(id);
    #0.1;
    chk(q_hit == exp_hit, {tag, " hit"}, q_hit, exp_hit);
    if (exp_hit) chk(q_prop == 8'(exp_prop), {tag, " prop"}, q_prop, exp_prop);
  endtask

  // write, then sit at the next falling edge
  task automatic wr(input int off, input bit is32, input logic [63:0] data);
    @(negedge clk);
    wr_en = 1; wr_off = 12'(off); wr_is32 = is32; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic no_effect(input string tag);
    chk(!mem_req, {tag, " no request"}, mem_req, 0);
    chk(wr_ready, {tag, " still ready"}, wr_ready, 1);
  endtask

  // expects an accepted write just issued; serves the fetch
  task automatic serve(input int id, input int newprop, input bit exp_recall, input string tag);
    longint ea;
    ea = longint'(prop_base) + id - 8192;
    chk(mem_req, {tag, " R6 req"}, mem_req, 1);
    chk(!wr_ready, {tag, " R6 busy"}, wr_ready, 0);
    chk(mem_addr == AW'(ea), {tag, " R6 addr"}, mem_addr, ea);
    @(negedge clk); @(negedge clk);
    chk(mem_req && mem_addr == AW'(ea), {tag, " R7 held"}, mem_addr, ea);
    mem_ack = 1; mem_rdata = 8'(newprop);
    @(negedge clk);
    mem_ack = 0;
    chk(wr_ready && !mem_req, {tag, " R7 done"}, wr_ready, 1);
    chk(recall == exp_recall, {tag, " R8 recall"}, recall, exp_recall);
    chk(reforward == (exp_recall && newprop[0]), {tag, " R8 reforward"}, reforward,
        exp_recall && newprop[0]);
    if (exp_recall) begin
      chk(refwd_id == IDB'(id), {tag, " R8 id"}, refwd_id, id);
      if (newprop[0]) chk(refwd_prio == 6'(newprop >> 2), {tag, " R8 prio"}, refwd_prio, newprop >> 2);
    end
    @(negedge clk);
    chk(!recall && !reforward, {tag, " R8 one pulse"}, recall, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(wr_ready && !mem_req && !recall && !reforward, "R6 reset idle", mem_req, 0);
    look(0, 0, 8192, 0, 0, "R5 reset empty");

    fill(0, 0, 0, 8192, 8'h11);
    fill(1, 0, 0, 16383, 8'h22);
    fill(2, 1, 5, 9000, 8'h33);
    fill(3, 0, 0, 12345, 8'h44);

    // R5 miss
    wr(12'h0A0, 0, 64'd8200);
    no_effect("R5 miss");
    // R1 wrong offset
    wr(12'h0A8, 0, 64'd16383);
    no_effect("R1 offset");
    look(0, 0, 16383, 1, 8'h22, "R1 entry kept");
    // R4 out of range ID
    fill(3, 0, 0, 100, 8'h55);
    wr(12'h0A0, 0, 64'd100);
    no_effect("R4 low id");
    look(0, 0, 100, 1, 8'h55, "R4 entry kept");
    fill(3, 0, 0, 12345, 8'h44);
    // R4 upper ID bits ignored: 0x32000 -> 8192
    wr(12'h0A0, 0, 64'h0000_0000_0003_2000);
    look(0, 0, 8192, 0, 0, "R6 invalidated");
    serve(8192, 8'h81, 0, "R4 upper bits");
    look(0, 0, 8192, 1, 8'h81, "R7 refilled");
    // R2 32-bit write drops virtual bit: miss on virtual entry
    wr(12'h0A0, 1, {1'b1, 15'h0, 16'd5, 32'd9000});
    no_effect("R2 zero extend");
    look(1, 5, 9000, 1, 8'h33, "R2 entry kept");
    // R2 32-bit write physical works
    wr(12'h0A0, 1, {32'hFFFF_FFFF, 32'd16383});
    serve(16383, 8'h0C, 0, "R2 32bit");
    look(0, 0, 16383, 1, 8'h0C, "R2 refilled");
    // R3 virtual with junk reserved and high vPE bits; forwarded match ignored (R9)
    fwd_valid = 1; fwd_id = IDB'(9000); fwd_active = 0;
    wr(12'h0A0, 0, {1'b1, 15'h7ABC, 16'hFFF5, 32'd9000});
    serve(9000, 8'hFD, 0, "R3 virtual R9");
    look(1, 5, 9000, 1, 8'hFD, "R3 refilled");
    // R3 physical with nonzero vPE bits -> vPE forced zero
    wr(12'h0A0, 0, {1'b0, 15'h1234, 16'h0007, 32'd12345});
    serve(12345, 8'h45, 0, "R3 physical");
    // R10 writes ignored while busy
    wr(12'h0A0, 0, 64'd12345);
    wr(12'h0A0, 0, 64'd16383);
    chk(!wr_ready, "R10 busy", wr_ready, 0);
    look(0, 0, 16383, 1, 8'h0C, "R10 entry kept during busy");
    @(negedge clk);
    serve(12345, 8'h46, 0, "R10 first");
    no_effect("R10 dropped write");
    look(0, 0, 16383, 1, 8'h0C, "R10 entry kept");
    // R11 reads
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    chk(rd_valid && rd_data == 0, "R11 read zero", rd_data, 0);
    no_effect("R11 no side effect");
    // R8/R9 sweep on every slot over forwarded/active/enable
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        int id, np;
        bit ex;
        id = 8192 + 1000 * s + c;
        fill(s, 0, 0, id, 8'h00);
        fwd_valid = c[0]; fwd_active = c[1]; fwd_id = IDB'(id);
        np = (c * 37 + s * 11) & 8'hFC | c[2];
        ex = c[0] && !c[1];
        wr(12'h0A0, 0, 64'(id));
        serve(id, np, ex, ex ? "R8 sweep" : "R9 sweep");
        look(0, 0, id, 1, np, "R7 sweep refill");
      end
    end
    // R9 forwarded ID differs
    fwd_valid = 1; fwd_active = 0; fwd_id = IDB'(8193);
    fill(0, 0, 0, 8192, 8'h01);
    wr(12'h0A0, 0, 64'd8192);
    serve(8192, 8'h09, 0, "R9 other id");
    // R6 base address change
    prop_base = 32'h0010_0F00;
    fwd_id = IDB'(8192);
    wr(12'h0A0, 0, 64'd8192);
    serve(8192, 8'hA5, 1, "R6 new base");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule